// File: doc/BRIEF.md
# Transmit FIFO with Interrupt Cause Register

This block holds the transmit data queue of a serial communication unit and a sticky interrupt-cause word. A producer pushes bytes into the queue and the transmitter pops them. Hardware watches the queue's fill level and the push and pop attempts. It sets cause bits for a fill level below a programmable threshold, for room left, for an empty queue, for a push that was refused and for a pop request that found nothing. Four single-cycle event inputs from neighbouring logic set four more cause bits: shared-memory access blocked, smartcard NACK, transfer done and arbitration lost.

Software reads the 32-bit cause word and clears bits by writing ones to them. A mask register selects which causes drive the single interrupt line, and the masked word can also be read. The usable queue capacity follows a width mode that selects the full, half or quarter depth of the storage. When the enable input is low, the queue is flushed and every cause bit is held at zero.

Top module: `tx_fifo_irq`

## Requirements
- R1: The cause word places the causes at these positions: bit 0 below-threshold, bit 1 room-left, bit 4 empty, bit 5 push-refused, bit 6 pop-on-empty, bit 7 access-blocked, bit 8 NACK, bit 9 done, bit 10 arbitration-lost. Bits 3:2 and 31:11 always read 0, and writing them has no effect.
- R2: Cause bits are zero after reset and stay set until cleared. A clear write (`clr_wr` high) clears each bit where `clr_data` holds a 1 and leaves each bit where it holds a 0 unchanged.
- R3: The below-threshold bit is set after any enabled cycle in which the fill level is less than `trig_level`.
- R4: Capacity is DEPTH for `width_mode` 0, DEPTH/2 for mode 1 and DEPTH/4 for modes 2 and 3. The room-left bit is set after any enabled cycle in which the fill level is below the capacity. A push is accepted only while the fill level is below the capacity.
- R5: The empty bit is set after any enabled cycle in which the fill level is zero.
- R6: A push while the fill level is at capacity sets the push-refused bit, and its data is discarded.
- R7: A pop request (`rd_req`) while the queue is empty sets the pop-on-empty bit.
- R8: While `en` is low, the queue is flushed, pushes and pops are ignored, and the cause word reads zero one cycle later.
- R9: A pulse on `ev_blocked`, `ev_nack`, `ev_done` or `ev_arb_lost` during an enabled cycle sets bit 7, 8, 9 or 10.
- R10: `masked_o` is the cause word ANDed with the mask register, which is loaded with `mask_wdata` when `mask_wr` is high. `irq_o` is high exactly when `masked_o` is nonzero.
- R11: If a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set. A cause bit shows its condition one cycle after the cycle in which the condition holds.
- R12: Bytes leave the queue in the order they were accepted. `rd_data` presents the popped byte one cycle after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low flushes the queue and clears the causes |
| width_mode | input | 2 | Capacity select: 0 full, 1 half, 2 and 3 quarter |
| trig_level | input | 4 | Threshold for the below-threshold cause |
| wr_valid | input | 1 | Push request |
| wr_data | input | DATA_W | Push data |
| rd_req | input | 1 | Pop request from the transmitter |
| rd_data | output | DATA_W | Popped byte, one cycle after the pop |
| ev_blocked | input | 1 | Access-blocked event pulse |
| ev_nack | input | 1 | Smartcard NACK event pulse |
| ev_done | input | 1 | Transfer-done event pulse |
| ev_arb_lost | input | 1 | Arbitration-lost event pulse |
| clr_wr | input | 1 | Cause clear strobe |
| clr_data | input | 32 | Ones select the cause bits to clear |
| mask_wr | input | 1 | Mask load strobe |
| mask_wdata | input | 32 | New mask value |
| cause_o | output | 32 | Sticky cause word |
| masked_o | output | 32 | Cause word ANDed with the mask |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that reserved bits stay zero, that set bits persist when no clear is written, that a low enable empties the cause word, and that the empty, push-refused, pop-on-empty and access-blocked conditions each raise their bit on the next cycle. Only the bench's scenarios can show that the per-mode capacity stops pushes at the right fill level, that refused data never comes out, that bytes leave in order, and that a set wins over a simultaneous clear. A seeded random run compares every output against a reference model.

// File: rtl/txq_pkg.sv
package txq_pkg;
  localparam int B_TRIG  = 0;
  localparam int B_ROOM  = 1;
  localparam int B_EMPTY = 4;
  localparam int B_OVF   = 5;
  localparam int B_UNF   = 6;
  localparam int B_BLK   = 7;
  localparam int B_NACK  = 8;
  localparam int B_DONE  = 9;
  localparam int B_ARB   = 10;
  localparam logic [31:0] CAUSE_USED = 32'h0000_07F3;

  typedef struct packed {
    logic arb;
    logic done;
    logic nack;
    logic blk;
    logic unf;
    logic ovf;
    logic empty;
    logic room;
    logic trig;
  } cause_set_t;

  function automatic logic [31:0] set_to_word(cause_set_t s);
    logic [31:0] w;
    w = '0;
    w[B_TRIG]  = s.trig;
    w[B_ROOM]  = s.room;
    w[B_EMPTY] = s.empty;
    w[B_OVF]   = s.ovf;
    w[B_UNF]   = s.unf;
    w[B_BLK]   = s.blk;
    w[B_NACK]  = s.nack;
    w[B_DONE]  = s.done;
    w[B_ARB]   = s.arb;
    return w;
  endfunction
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        width_mode,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_req,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     fill,
  output logic              full,
  output logic              empty,
  output logic [CW-1:0]     cap
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wp, rp;
  logic              do_push, do_pop;

  always_comb begin
    case (width_mode)
      2'd0:    cap = CW'(DEPTH);
      2'd1:    cap = CW'(DEPTH / 2);
      default: cap = CW'(DEPTH / 4);
    endcase
  end

  assign full    = (fill >= cap);
  assign empty   = (fill == '0);
  assign do_push = en && push_req && !full;
  assign do_pop  = en && pop_req && !empty;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (do_pop) pop_data <= mem[rp];
  end
endmodule

// File: rtl/txq_cause.sv
module txq_cause
  import txq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [31:0] set_vec,
  input  logic        clr_wr,
  input  logic [31:0] clr_data,
  output logic [31:0] cause_q
);
  logic [31:0] clr_eff;

  assign clr_eff = clr_wr ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (rst || !en) cause_q <= '0;
    else            cause_q <= ((cause_q & ~clr_eff) | set_vec) & CAUSE_USED;
  end
endmodule

// File: rtl/tx_fifo_irq.sv
module tx_fifo_irq
  import txq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int TRIG_W = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [1:0]        width_mode,
  input  logic [TRIG_W-1:0] trig_level,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ev_blocked,
  input  logic              ev_nack,
  input  logic              ev_done,
  input  logic              ev_arb_lost,
  input  logic              clr_wr,
  input  logic [31:0]       clr_data,
  input  logic              mask_wr,
  input  logic [31:0]       mask_wdata,
  output logic [31:0]       cause_o,
  output logic [31:0]       masked_o,
  output logic              irq_o
);
  logic [CW-1:0] fill_w, cap_w;
  logic          full_w, empty_w;
  cause_set_t    sets;
  logic [31:0]   mask_q;

  txq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .en(en), .width_mode(width_mode),
    .push_req(wr_valid), .push_data(wr_data),
    .pop_req(rd_req), .pop_data(rd_data),
    .fill(fill_w), .full(full_w), .empty(empty_w), .cap(cap_w)
  );

  always_comb begin
    sets       = '0;
    sets.trig  = (fill_w < CW'(trig_level));
    sets.room  = (fill_w < cap_w);
    sets.empty = empty_w;
    sets.ovf   = wr_valid && full_w;
    sets.unf   = rd_req && empty_w;
    sets.blk   = ev_blocked;
    sets.nack  = ev_nack;
    sets.done  = ev_done;
    sets.arb   = ev_arb_lost;
  end

  txq_cause u_cause (
    .clk(clk), .rst(rst), .en(en),
    .set_vec(set_to_word(sets)),
    .clr_wr(clr_wr), .clr_data(clr_data),
    .cause_q(cause_o)
  );

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata & CAUSE_USED;
  end

  assign masked_o = cause_o & mask_q;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/tx_fifo_irq_chk.sv
module tx_fifo_irq_chk
  import txq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          wr_valid,
  input logic          rd_req,
  input logic          ev_blocked,
  input logic          clr_wr,
  input logic [31:0]   cause_o,
  input logic          irq_o,
  input logic [CW-1:0] fill,
  input logic          full
);
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (cause_o & ~CAUSE_USED) == 32'h0);

  p_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !clr_wr) |=> (($past(cause_o) & ~cause_o) == 32'h0));

  p_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (en && fill == '0) |=> cause_o[B_EMPTY]);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (en && wr_valid && full) |=> cause_o[B_OVF]);

  p_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (en && rd_req && fill == '0) |=> cause_o[B_UNF]);

  p_disable_wipe_r8: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cause_o == 32'h0));

  p_blocked_r9: assert property (@(posedge clk) disable iff (rst)
    (en && ev_blocked) |=> cause_o[B_BLK]);

  p_irq_has_cause_r10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (cause_o != 32'h0));

  p_fill_bound_r4: assert property (@(posedge clk) disable iff (rst)
    fill <= CW'(DEPTH));
endmodule

bind tx_fifo_irq tx_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .en(en), .wr_valid(wr_valid), .rd_req(rd_req),
  .ev_blocked(ev_blocked), .clr_wr(clr_wr), .cause_o(cause_o),
  .irq_o(irq_o), .fill(fill_w), .full(full_w)
);

// File: tb/tx_fifo_irq_test.sv
module tx_fifo_irq_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 16;
  localparam logic [31:0] USED = 32'h0000_07F3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic [1:0] width_mode = 2'd0;
  logic [3:0] trig_level = 4'd4;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic rd_req = 1'b0;
  logic [7:0] rd_data;
  logic ev_blocked = 1'b0, ev_nack = 1'b0, ev_done = 1'b0, ev_arb_lost = 1'b0;
  logic clr_wr = 1'b0;
  logic [31:0] clr_data = 32'h0;
  logic mask_wr = 1'b0;
  logic [31:0] mask_wdata = 32'h0;
  logic [31:0] cause_o, masked_o;
  logic irq_o;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] m_cause = 32'h0;
  logic [31:0] m_mask = 32'h0;
  logic [7:0] m_q[$];

  always #(PERIOD/2) clk = ~clk;

  tx_fifo_irq uut (
    .clk(clk), .rst(rst), .en(en), .width_mode(width_mode), .trig_level(trig_level),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
    .ev_blocked(ev_blocked), .ev_nack(ev_nack), .ev_done(ev_done), .ev_arb_lost(ev_arb_lost),
    .clr_wr(clr_wr), .clr_data(clr_data), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .cause_o(cause_o), .masked_o(masked_o), .irq_o(irq_o)
  );

  function automatic int cap_of(logic [1:0] m);
    return (m == 2'd0) ? DEPTH : (m == 2'd1) ? DEPTH / 2 : DEPTH / 4;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: predict, step, compare; then drop the single-cycle strobes
  task automatic tick(string tag);
    int cnt, c;
    logic [31:0] s, nc;
    logic do_pop;
    logic [7:0] exp_rd;
    cnt = m_q.size();
    c = cap_of(width_mode);
    s = 32'h0;
    exp_rd = 8'h00;
    if (en) begin
      s[0] = (cnt < int'(trig_level));
      s[1] = (cnt < c);
      s[4] = (cnt == 0);
      s[5] = wr_valid && (cnt >= c);
      s[6] = rd_req && (cnt == 0);
      s[7] = ev_blocked;
      s[8] = ev_nack;
      s[9] = ev_done;
      s[10] = ev_arb_lost;
    end
    nc = en ? (((m_cause & ~(clr_wr ? clr_data : 32'h0)) | s) & USED) : 32'h0;
    do_pop = en && rd_req && (cnt > 0);
    if (do_pop) exp_rd = m_q.pop_front();
    if (en && wr_valid && cnt < c) m_q.push_back(wr_data);
    if (!en) m_q.delete();
    if (mask_wr) m_mask = mask_wdata & USED;
    @(posedge clk);
    @(negedge clk);
    m_cause = nc;
    chk({tag, " cause"}, cause_o, m_cause);
    chk({tag, " masked"}, masked_o, m_cause & m_mask);
    chk({tag, " irq"}, {31'h0, irq_o}, {31'h0, (m_cause & m_mask) != 0});
    if (do_pop) chk({tag, " rd_data"}, {24'h0, rd_data}, {24'h0, exp_rd});
    wr_valid = 0; rd_req = 0; clr_wr = 0; mask_wr = 0;
    ev_blocked = 0; ev_nack = 0; ev_done = 0; ev_arb_lost = 0;
  endtask

  task automatic clear_all(string tag);
    clr_wr = 1; clr_data = 32'hFFFF_FFFF;
    tick(tag);
  endtask

  bit done = 0;

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R2: reset state
    chk("R2 reset cause", cause_o, 32'h0);
    chk("R2 reset irq", {31'h0, irq_o}, 32'h0);

    en = 1; width_mode = 0; trig_level = 4'd4;
    tick("R3");
    chk("R3 idle causes", cause_o, 32'h13);
    chk("R5 empty bit", {31'h0, cause_o[4]}, 32'h1);

    // R11: clear loses to a set in the same cycle
    clr_wr = 1; clr_data = 32'h13;
    tick("R11");
    chk("R11 set wins", cause_o, 32'h13);

    for (int i = 0; i < DEPTH; i++) begin
      wr_valid = 1; wr_data = 8'(i * 7 + 3);
      tick("R12");
    end
    clear_all("R4");
    chk("R4 full mode0 no room", cause_o, 32'h0);
    wr_valid = 1; wr_data = 8'hEE;
    tick("R6");
    chk("R6 overflow only", cause_o, 32'h20);
    for (int i = 0; i < DEPTH; i++) begin
      rd_req = 1;
      tick("R12");
    end
    rd_req = 1;
    tick("R7");
    chk("R7 underflow", {31'h0, cause_o[6]}, 32'h1);

    for (int m = 1; m <= 3; m++) begin
      en = 0;
      tick("R8");
      chk("R8 disabled cause", cause_o, 32'h0);
      en = 1; width_mode = 2'(m);
      for (int i = 0; i < cap_of(2'(m)); i++) begin
        wr_valid = 1; wr_data = 8'(8'h40 + m * 16 + i);
        tick("R4");
      end
      clear_all("R4");
      chk("R4 at capacity", {31'h0, cause_o[1]}, 32'h0);
      wr_valid = 1; wr_data = 8'hAA;
      tick("R6");
      chk("R6 refused push", {31'h0, cause_o[5]}, 32'h1);
      for (int i = 0; i < cap_of(2'(m)); i++) begin
        rd_req = 1;
        tick("R12");
      end
    end

    ev_blocked = 1; tick("R9");
    chk("R9 blocked", {31'h0, cause_o[7]}, 32'h1);
    ev_nack = 1; tick("R9");
    chk("R9 nack", {31'h0, cause_o[8]}, 32'h1);
    ev_done = 1; ev_arb_lost = 1; tick("R9");
    chk("R9 done+arb", {30'h0, cause_o[10:9]}, 32'h3);

    clr_wr = 1; clr_data = 32'h0; tick("R2");
    chk("R2 zero write keeps", cause_o & 32'h780, 32'h780);
    clr_wr = 1; clr_data = ~USED; tick("R1");
    chk("R1 reserved zero", cause_o & ~USED, 32'h0);

    mask_wr = 1; mask_wdata = 32'hFFFF_F100; tick("R10");
    chk("R10 irq on", {31'h0, irq_o}, 32'h1);
    chk("R10 masked", masked_o, 32'h100);
    clr_wr = 1; clr_data = 32'h100; tick("R10");
    chk("R10 irq off", {31'h0, irq_o}, 32'h0);

    en = 0; tick("R8");
    chk("R8 wipe", cause_o, 32'h0);
    en = 1;

    for (int k = 0; k < 3000; k++) begin
      en = ($urandom % 40) != 0;
      if (($urandom % 50) == 0) width_mode = 2'($urandom);
      if (($urandom % 60) == 0) trig_level = 4'($urandom);
      wr_valid = ($urandom % 2) == 0;
      wr_data = 8'($urandom);
      rd_req = ($urandom % 3) == 0;
      ev_blocked = ($urandom % 20) == 0;
      ev_nack = ($urandom % 20) == 0;
      ev_done = ($urandom % 20) == 0;
      ev_arb_lost = ($urandom % 20) == 0;
      clr_wr = ($urandom % 4) == 0;
      clr_data = $urandom;
      mask_wr = ($urandom % 30) == 0;
      mask_wdata = $urandom;
      tick("R2");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule